// File: doc/BRIEF.md
# Packed Lane Shift, Rotate and Shuffle Unit

This unit takes a 64-bit packed operand and shifts or rotates it lane by lane. A lane is 16 bits, 32 bits or the whole 64-bit word. Each lane is treated on its own, so no bit ever crosses from one lane into the next. The same datapath also reorders the four halfwords of the operand under an 8-bit selector. It also pulls a 64-bit window out of the 128-bit pair formed by two operands, at a byte offset.

Each accepted request produces a 64-bit result and a 32-bit status word one clock later. For every shift, rotate and shuffle, the status word carries a negative flag and a zero flag for each lane. The byte extract leaves the status word untouched. The unit sits in a SIMD execute stage and accepts a new request on any cycle.

Top module: `pkshift_unit`

## Requirements
- R1: Op 0 is a logical right shift and op 1 is a logical left shift. Each acts on every lane of the selected size on its own: size 0 means 16-bit lanes, size 1 means 32-bit lanes, and size 2 or 3 means one 64-bit lane. Bits that leave a lane are lost, and vacated bits become zero.
- R2: A logical shift whose 8-bit amount is equal to or greater than the lane width makes every lane zero.
- R3: Op 2 is an arithmetic right shift. It fills each lane from that lane's own top bit. An amount equal to or greater than the lane width fills the whole lane with copies of that bit.
- R4: Op 3 rotates each lane right by the amount taken modulo the lane width.
- R5: Op 4 is the shuffle. Result halfword i (bits 16i+15:16i) is the operand A halfword numbered by amount bits [2i+1:2i]. The size input has no effect.
- R6: Op 5 is the extract, with n taken from amount bits [2:0]. It returns the low 64 bits of {B, A} shifted right by 8n. So n = 0 returns A, and amount bits [7:3] and the size have no effect.
- R7: After ops 0 to 4, each lane i of L lanes writes two flags into the status word. Its negative flag, a copy of the lane's top bit, goes to bit (32/L)(i+1)-1. Its zero flag goes to the bit just below. All other status bits are zero. For the 64-bit size this puts negative at bit 31 and zero at bit 30. The shuffle always uses the 16-bit layout.
- R8: The extract leaves the status word unchanged.
- R9: Op codes 6 and 7 leave both result and status unchanged.
- R10: Result and status are loaded on the clock edge that samples in_valid high, and out_valid is high in the cycle that follows. When in_valid is low, result and status hold their values.
- R11: Reset clears result, status and out_valid to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid_i | input | 1 | Request strobe |
| op_a_i | input | 64 | Operand A (shifted, shuffled, extract low half) |
| op_b_i | input | 64 | Operand B (extract high half) |
| amt_i | input | 8 | Shift/rotate amount, shuffle selector or extract offset |
| size_i | input | 2 | Lane size: 0 = 16, 1 = 32, 2/3 = 64 bits |
| op_i | input | 3 | Operation code |
| out_valid_o | output | 1 | Result valid, one cycle after request |
| result_o | output | 64 | Registered result |
| status_o | output | 32 | Registered per-lane negative/zero flags |

## Verification
The assertions assume that in_valid_i and the other request inputs are stable around the sampling edge. The bench meets this by changing them only on the falling clock edge. They also assume that every op code, including the reserved ones, may arrive back to back with no idle cycle. The random stimulus covers the full 8-bit amount range, so amounts at and beyond each lane width occur naturally. Directed cases also place amounts exactly on the lane widths and give the extract offsets with the upper amount bits set.

// File: rtl/pkshift_pkg.sv
package pkshift_pkg;
  typedef enum logic [2:0] {
    OP_SRL  = 3'd0,
    OP_SLL  = 3'd1,
    OP_SRA  = 3'd2,
    OP_ROR  = 3'd3,
    OP_SHUF = 3'd4,
    OP_EXTR = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } pk_op_e;

  // lane granularity index: 0 -> 16 bit, 1 -> 32 bit, 2 -> 64 bit
  localparam int unsigned NUM_GRAN = 3;
  localparam int unsigned BASE_LANE_W = 16;
endpackage

// File: rtl/pkshift_lane_shift.sv
// One lane: logical right/left, arithmetic right, rotate right.
module pkshift_lane_shift #(
  parameter int unsigned LW = 16,
  parameter int unsigned AW = 8
) (
  input  logic [LW-1:0] lane_i,
  input  logic [AW-1:0] amt_i,
  input  logic [1:0]    kind_i,
  output logic [LW-1:0] lane_o
);
  localparam int unsigned SHW = $clog2(LW);

  logic            over_w;
  logic [SHW-1:0]  sh;
  logic [2*LW-1:0] dbl;
  logic [LW-1:0]   srl_v, sll_v, sra_v, ror_v;

  assign over_w = (amt_i >= AW'(LW));
  assign sh     = amt_i[SHW-1:0];
  assign dbl    = {lane_i, lane_i} >> sh;

  always_comb begin
    srl_v = over_w ? '0 : (lane_i >> sh);
    sll_v = over_w ? '0 : (lane_i << sh);
    sra_v = over_w ? {LW{lane_i[LW-1]}} : LW'($signed(lane_i) >>> sh);
    ror_v = dbl[LW-1:0];
    case (kind_i)
      2'd0:    lane_o = srl_v;
      2'd1:    lane_o = sll_v;
      2'd2:    lane_o = sra_v;
      default: lane_o = ror_v;
    endcase
  end
endmodule

// File: rtl/pkshift_packed_shift.sv
// Splits the word into DW/LW lanes and shifts each on its own.
module pkshift_packed_shift #(
  parameter int unsigned DW = 64,
  parameter int unsigned LW = 16,
  parameter int unsigned AW = 8
) (
  input  logic [DW-1:0] val_i,
  input  logic [AW-1:0] amt_i,
  input  logic [1:0]    kind_i,
  output logic [DW-1:0] val_o
);
  localparam int unsigned NLANE = DW / LW;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    pkshift_lane_shift #(.LW(LW), .AW(AW)) u_lane (
      .lane_i (val_i[i*LW +: LW]),
      .amt_i  (amt_i),
      .kind_i (kind_i),
      .lane_o (val_o[i*LW +: LW])
    );
  end
endmodule

// File: rtl/pkshift_shuffle.sv
// Halfword reorder: output halfword i picks source halfword sel[2i+1:2i].
module pkshift_shuffle #(
  parameter int unsigned DW = 64,
  parameter int unsigned HW = 16
) (
  input  logic [DW-1:0]            val_i,
  input  logic [2*(DW/HW)-1:0]     sel_i,
  output logic [DW-1:0]            val_o
);
  localparam int unsigned NH = DW / HW;

  for (genvar i = 0; i < NH; i++) begin : g_hw
    logic [1:0] pick;
    assign pick = sel_i[2*i +: 2];
    assign val_o[i*HW +: HW] = val_i[pick*HW +: HW];
  end
endmodule

// File: rtl/pkshift_funnel.sv
// Byte-offset window across the {hi, lo} operand pair.
module pkshift_funnel #(
  parameter int unsigned DW = 64,
  parameter int unsigned OW = $clog2(DW/8)
) (
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  logic [OW-1:0] ofs_i,
  output logic [DW-1:0] val_o
);
  logic [2*DW-1:0] pair_sh;
  assign pair_sh = {hi_i, lo_i} >> {ofs_i, 3'b000};
  assign val_o   = pair_sh[DW-1:0];
endmodule

// File: rtl/pkshift_flags.sv
// Per-lane negative/zero flags placed at the top two bits of each lane field.
module pkshift_flags #(
  parameter int unsigned DW = 64,
  parameter int unsigned SW = 32
) (
  input  logic [DW-1:0] val_i,
  input  logic [1:0]    gran_i,
  output logic [SW-1:0] flags_o
);
  import pkshift_pkg::*;

  logic [SW-1:0] fl_g [NUM_GRAN];

  for (genvar g = 0; g < NUM_GRAN; g++) begin : g_gran
    localparam int unsigned LW    = BASE_LANE_W << g;
    localparam int unsigned NLANE = DW / LW;
    localparam int unsigned FW    = SW / NLANE;
    logic [SW-1:0] fv;
    always_comb begin
      fv = '0;
      for (int i = 0; i < NLANE; i++) begin
        fv[FW*(i+1)-1] = val_i[LW*(i+1)-1];
        fv[FW*(i+1)-2] = ~|val_i[LW*i +: LW];
      end
    end
    assign fl_g[g] = fv;
  end

  always_comb begin
    case (gran_i)
      2'd0:    flags_o = fl_g[0];
      2'd1:    flags_o = fl_g[1];
      default: flags_o = fl_g[2];
    endcase
  end
endmodule

// File: rtl/pkshift_unit.sv
module pkshift_unit #(
  parameter int unsigned DW = 64,
  parameter int unsigned AW = 8,
  parameter int unsigned SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid_i,
  input  logic [DW-1:0] op_a_i,
  input  logic [DW-1:0] op_b_i,
  input  logic [AW-1:0] amt_i,
  input  logic [1:0]    size_i,
  input  logic [2:0]    op_i,
  output logic          out_valid_o,
  output logic [DW-1:0] result_o,
  output logic [SW-1:0] status_o
);
  import pkshift_pkg::*;

  localparam int unsigned OW = $clog2(DW/8);
  localparam int unsigned NH = DW / BASE_LANE_W;
  localparam logic [SW-1:0] FLAG_MASK = {(SW/8){8'hC0}};

  pk_op_e        op_e;
  logic [1:0]    gran;
  logic [DW-1:0] res_g [NUM_GRAN];
  logic [DW-1:0] shift_res, shuf_res, fun_res;
  logic [DW-1:0] flag_val;
  logic [1:0]    flag_gran;
  logic [SW-1:0] flag_w;

  logic [DW-1:0] res_d, result_q;
  logic [SW-1:0] st_d, status_q;
  logic          vld_q;

  assign op_e = pk_op_e'(op_i);
  assign gran = (size_i == 2'd3) ? 2'd2 : size_i;

  // one packed shifter per lane granularity, selected afterwards
  for (genvar g = 0; g < NUM_GRAN; g++) begin : g_shift
    pkshift_packed_shift #(.DW(DW), .LW(BASE_LANE_W << g), .AW(AW)) u_shift (
      .val_i  (op_a_i),
      .amt_i  (amt_i),
      .kind_i (op_i[1:0]),
      .val_o  (res_g[g])
    );
  end

  always_comb begin
    case (gran)
      2'd0:    shift_res = res_g[0];
      2'd1:    shift_res = res_g[1];
      default: shift_res = res_g[2];
    endcase
  end

  pkshift_shuffle #(.DW(DW), .HW(BASE_LANE_W)) u_shuffle (
    .val_i (op_a_i),
    .sel_i (amt_i[2*NH-1:0]),
    .val_o (shuf_res)
  );

  pkshift_funnel #(.DW(DW), .OW(OW)) u_funnel (
    .lo_i  (op_a_i),
    .hi_i  (op_b_i),
    .ofs_i (amt_i[OW-1:0]),
    .val_o (fun_res)
  );

  assign flag_val  = (op_e == OP_SHUF) ? shuf_res : shift_res;
  assign flag_gran = (op_e == OP_SHUF) ? 2'd0 : gran;

  pkshift_flags #(.DW(DW), .SW(SW)) u_flags (
    .val_i   (flag_val),
    .gran_i  (flag_gran),
    .flags_o (flag_w)
  );

  // next-state
  always_comb begin
    res_d = result_q;
    st_d  = status_q;
    case (op_e)
      OP_SRL, OP_SLL, OP_SRA, OP_ROR, OP_SHUF: begin
        res_d = flag_val;
        st_d  = flag_w;
      end
      OP_EXTR: res_d = fun_res;
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      result_q <= '0;
      status_q <= '0;
    end else begin
      vld_q <= in_valid_i;
      if (in_valid_i) begin
        result_q <= res_d;
        status_q <= st_d;
      end
    end
  end

  assign out_valid_o = vld_q;
  assign result_o    = result_q;
  assign status_o    = status_q;

  // assertions
  a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);
  a_r10_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o);
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> ($stable(result_o) && $stable(status_o)));
  a_r8_extract_status: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i == 3'd5) |=> $stable(status_o));
  a_r9_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i[2:1] == 2'b11) |=> ($stable(result_o) && $stable(status_o)));
  a_r6_extract_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i == 3'd5 && amt_i[OW-1:0] == '0) |=> (result_o == $past(op_a_i)));
  a_r5_shuffle_ident: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i == 3'd4 && amt_i[7:0] == 8'hE4) |=> (result_o == $past(op_a_i)));
  a_r2_logical_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i[2:1] == 2'b00 && amt_i >= AW'(DW)) |=> (result_o == '0));
  a_r7_flag_layout: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & ~FLAG_MASK) == '0);
endmodule

// File: tb/pkshift_unit_bench.sv
module pkshift_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] op_a, op_b;
  logic [7:0]  amt;
  logic [1:0]  size;
  logic [2:0]  op;
  logic        out_valid;
  logic [63:0] result;
  logic [31:0] status;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [63:0] exp_res;
  logic [31:0] exp_st;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkshift_unit u_pkshift_unit (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid),
    .op_a_i(op_a), .op_b_i(op_b), .amt_i(amt), .size_i(size), .op_i(op),
    .out_valid_o(out_valid), .result_o(result), .status_o(status)
  );

  function automatic int lane_w(input logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 32 : 64;
  endfunction

  function automatic logic [63:0] m_shift(input logic [63:0] a, input int n,
                                           input int lw, input int kind);
    logic [63:0] r = '0;
    for (int base = 0; base < 64; base += lw) begin
      for (int j = 0; j < lw; j++) begin
        int s;
        case (kind)
          0: begin s = j + n; r[base+j] = (s < lw) ? a[base+s] : 1'b0; end
          1: begin s = j - n; r[base+j] = (s >= 0) ? a[base+s] : 1'b0; end
          2: begin s = j + n; r[base+j] = (s < lw) ? a[base+s] : a[base+lw-1]; end
          default: begin s = (j + (n % lw)) % lw; r[base+j] = a[base+s]; end
        endcase
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] m_flags(input logic [63:0] v, input int lw);
    logic [31:0] f = '0;
    int nl = 64 / lw;
    int fw = 32 / nl;
    for (int i = 0; i < nl; i++) begin
      f[fw*(i+1)-1] = v[lw*(i+1)-1];
      f[fw*(i+1)-2] = (((v >> (lw*i)) & ((lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF
                        : ((64'd1 << lw) - 1))) == 64'd0);
    end
    return f;
  endfunction

  function automatic logic [63:0] m_shuf(input logic [63:0] a, input logic [7:0] sel);
    logic [63:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      int s = (sel >> (2*i)) & 3;
      for (int k = 0; k < 16; k++) r[16*i+k] = a[16*s+k];
    end
    return r;
  endfunction

  function automatic logic [63:0] m_extr(input logic [63:0] a, input logic [63:0] b,
                                          input int n);
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++) begin
      int s = k + n;
      for (int t = 0; t < 8; t++)
        r[8*k+t] = (s < 8) ? a[8*s+t] : b[8*(s-8)+t];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drives a request at the current falling edge, checks it at the next one.
  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [7:0] n,
                        input logic [1:0] s, input logic [2:0] o);
    string rtag, stag;
    int lw = lane_w(s);
    in_valid = 1'b1; op_a = a; op_b = b; amt = n; size = s; op = o;
    case (o)
      3'd0, 3'd1: begin
        exp_res = m_shift(a, n, lw, o); exp_st = m_flags(exp_res, lw);
        rtag = (n >= lw) ? "R2" : "R1"; stag = "R7";
      end
      3'd2: begin exp_res = m_shift(a, n, lw, 2); exp_st = m_flags(exp_res, lw);
                  rtag = "R3"; stag = "R7"; end
      3'd3: begin exp_res = m_shift(a, n, lw, 3); exp_st = m_flags(exp_res, lw);
                  rtag = "R4"; stag = "R7"; end
      3'd4: begin exp_res = m_shuf(a, n); exp_st = m_flags(exp_res, 16);
                  rtag = "R5"; stag = "R7"; end
      3'd5: begin exp_res = m_extr(a, b, n[2:0]); rtag = "R6"; stag = "R8"; end
      default: begin rtag = "R9"; stag = "R9"; end
    endcase
    @(negedge clk);
    chk("R10", {63'd0, out_valid}, 64'd1);
    chk(rtag, result, exp_res);
    chk(stag, {32'd0, status}, {32'd0, exp_st});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; amt = '0; size = '0; op = '0;
    exp_res = '0; exp_st = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", result, 64'd0);
    chk("R11", {32'd0, status}, 64'd0);
    chk("R11", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corner cases
    run_op(64'h8001_7FFE_0F0F_F000, '0, 8'd4,   2'd0, 3'd0); // R1 srl 16
    run_op(64'h8001_7FFE_0F0F_F001, '0, 8'd31,  2'd1, 3'd1); // R1 sll 32 edge
    run_op(64'hFFFF_FFFF_FFFF_FFFF, '0, 8'd16,  2'd0, 3'd0); // R2 exactly width
    run_op(64'hFFFF_FFFF_FFFF_FFFF, '0, 8'd64,  2'd3, 3'd1); // R2 64-bit
    run_op(64'h8000_7FFF_8123_0001, '0, 8'd20,  2'd0, 3'd2); // R3 full sign fill
    run_op(64'h8000_0000_1234_5678, '0, 8'd200, 2'd2, 3'd2); // R3 64-bit wide amt
    run_op(64'h8000_0001_0000_0003, '0, 8'd33,  2'd1, 3'd3); // R4 mod width
    run_op(64'h1234_5678_9ABC_DEF0, '0, 8'd0,   2'd0, 3'd3); // R4 zero rotate
    run_op(64'h1111_2222_3333_4444, '0, 8'hE4,  2'd2, 3'd4); // R5 identity
    run_op(64'h0000_8000_1234_0000, '0, 8'h1B,  2'd1, 3'd4); // R5 reverse
    run_op(64'h0102_0304_0506_0708, 64'hA1A2_A3A4_A5A6_A7A8, 8'hF8, 2'd1, 3'd5); // R6 n=0
    run_op(64'h0102_0304_0506_0708, 64'hA1A2_A3A4_A5A6_A7A8, 8'hFB, 2'd0, 3'd5); // R6 n=3, R8
    run_op(64'hDEAD_BEEF_0000_0000, 64'h5, 8'd3, 2'd0, 3'd6);                   // R9
    run_op(64'hDEAD_BEEF_0000_0000, 64'h5, 8'd3, 2'd2, 3'd7);                   // R9
    run_op(64'h0000_0000_0000_0000, '0, 8'd1,   2'd3, 3'd0); // R7 zero flags 64-bit

    // R10: idle holds result and status
    in_valid = 1'b0; op = 3'd1; amt = 8'd5; op_a = 64'hFFFF;
    @(negedge clk);
    chk("R10", {63'd0, out_valid}, 64'd0);
    chk("R10", result, exp_res);
    chk("R10", {32'd0, status}, {32'd0, exp_st});

    // constrained random
    for (int k = 0; k < 600; k++) begin
      logic [63:0] a, b;
      logic [7:0]  n;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (($urandom % 8) == 0) a = '0;
      n = (($urandom % 2) == 0) ? 8'($urandom % 70) : 8'($urandom);
      run_op(a, b, n, 2'($urandom), 3'($urandom));
    end

    // R11: reset after activity
    run_op(64'hFFFF_0000_FFFF_0000, '0, 8'd1, 2'd0, 3'd1);
    rst_n = 1'b0; in_valid = 1'b0;
    #1;
    chk("R11", result, 64'd0);
    chk("R11", {32'd0, status}, 64'd0);
    chk("R11", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule